// File: doc/BRIEF.md
# PHY Management Register Front End

This block is the management face of a 10/100 Ethernet PHY as a MAC host sees it through its management command registers. It keeps sixteen 16-bit PHY registers with fixed power-on contents. The status and identifier words cannot be written. Setting the top bit of a control write reloads the whole file. A link-status input rewrites the link bit of the status word and the partner-ability word. The host port has five registers: an address register (PHY address and register address), a transmit-data register, a command register, a receive-data register and a management status register carrying a link-fail flag. The serial management bit timing, auto-negotiation and extended registers are not part of this block.

The host uses a single-cycle synchronous register interface with 32-bit data. Host register indices are: 0 command, 1 address, 2 transmit data, 3 receive data, 4 management status. Indices 5 to 7 are unmapped. A small command sequencer runs the operations a command write asks for. It has three states. SEQ_IDLE waits for a command. SEQ_WRITE performs the PHY write using the stored address and transmit data. SEQ_READ captures the addressed PHY word into the receive-data register. Its transitions are: SEQ_IDLE to SEQ_WRITE when the write bit is set; SEQ_IDLE to SEQ_READ when only the read bit is set; SEQ_WRITE to SEQ_READ when the accepted command also asked for a read; SEQ_WRITE to SEQ_IDLE otherwise; and SEQ_READ to SEQ_IDLE always. Writing the transmit-data register while the responding PHY is addressed updates the PHY register at once, with no command needed.

Top module: `phy_mgmt_front`

## Requirements
- R1: After reset every host register reads 0. The PHY words read control 0x1000, status 0x7848, identifier-1 0x2000, identifier-2 0x5C90, advertisement 0x01E1, and every other index 0, with the link state then applied.
- R2: At each change of `link_up`, status bit 2 follows the new level on the next edge. On a rise, 0x01E1 is ORed into word 5. On a fall, word 5 is ANDed with 0x01FF.
- R3: A PHY write to word 0 with bit 15 set reloads all sixteen words with their reset values and re-applies the current link state, instead of storing the value.
- R4: Writes to words 1, 2 and 3 are ignored. Writes to any other word below 16 store the 16-bit value, including word 0 when bit 15 is clear.
- R5: The address register keeps the PHY address in bits 4:0 and the register address in bits 12:8. All other bits read 0.
- R6: Command register bits: bit 2 requests a PHY write, bit 1 requests a PHY read, bit 0 enables link scanning (and reads back). A command with both bits 2 and 1 set writes first and then reads the word just written. Receive data is valid two edges after the command write.
- R7: Only PHY address 1 (parameter `PHY_ADDR`) responds. A read to any other PHY address loads 0xFFFF into receive data, and writes to it change nothing.
- R8: A transmit-data write latches bits 15:0. While PHY address 1 is selected, the same edge writes that value to the addressed PHY word.
- R9: Every PHY read sets the link-fail flag (bit 0 of host register 4) to the inverse of `link_up`.
- R10: While scanning is enabled, each change of `link_up` sets link-fail to its inverse on the next edge. While scanning is disabled, link changes leave link-fail untouched.
- R11: A register address of 16 or above reads as 0 from the responding PHY, and writes to it are ignored. The address does not alias onto a lower word.
- R12: A command written while the sequencer is not in SEQ_IDLE starts no operation. Only its scan bit is taken.
- R13: `host_rdata` is registered: it presents the addressed register on the edge where `host_rd_en` is high and holds otherwise. Unmapped host indices read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_rd_en | input | 1 | Host register read strobe |
| host_addr | input | HOST_AW | Host register index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| link_up | input | 1 | Current link state, 1 = up |

## Verification
A corrupted PHY word or a stuck link bit does not show by itself. It appears only in the receive-data register after the next read command, two edges after the command write, and then one more edge later on the host read port. A wrong sequencer state shows as a dropped or duplicated write, which can only be seen on a later read of the same word. For that reason the bench mirrors all sixteen words and compares each randomized read against its model. A wrong link-fail flag is visible at the next status read, so scan and read updates are checked right after each link toggle.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
    localparam int PHY_DW = 16;
    localparam int NREG   = 16;
    localparam int IDX_W  = $clog2(NREG);
    localparam int FLD_W  = 5;

    localparam int unsigned RI_CTRL = 0;
    localparam int unsigned RI_STAT = 1;
    localparam int unsigned RI_ID1  = 2;
    localparam int unsigned RI_ID2  = 3;
    localparam int unsigned RI_ADV  = 4;
    localparam int unsigned RI_LPA  = 5;

    localparam int SOFT_RST_BIT = 15;
    localparam logic [PHY_DW-1:0] LINK_MASK   = 16'h0004;
    localparam logic [PHY_DW-1:0] LPA_UP_SET  = 16'h01E1;
    localparam logic [PHY_DW-1:0] LPA_DN_KEEP = 16'h01FF;

    localparam int unsigned HR_CMD  = 0;
    localparam int unsigned HR_ADDR = 1;
    localparam int unsigned HR_TXD  = 2;
    localparam int unsigned HR_RXD  = 3;
    localparam int unsigned HR_STS  = 4;

    localparam int CMD_SCAN_BIT = 0;
    localparam int CMD_RD_BIT   = 1;
    localparam int CMD_WR_BIT   = 2;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_WRITE,
        SEQ_READ
    } seq_state_t;

    function automatic logic [PHY_DW-1:0] phy_reset_value(int unsigned idx);
        case (idx)
            RI_CTRL: return 16'h1000;
            RI_STAT: return 16'h7848;
            RI_ID1:  return 16'h2000;
            RI_ID2:  return 16'h5C90;
            RI_ADV:  return 16'h01E1;
            default: return '0;
        endcase
    endfunction

    function automatic logic is_read_only(int unsigned idx);
        return (idx == RI_STAT) || (idx == RI_ID1) || (idx == RI_ID2);
    endfunction
endpackage

// File: rtl/phy_regfile.sv
module phy_regfile
    import phy_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_up,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PHY_DW-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [PHY_DW-1:0] rd_data
);
    logic [NREG-1:0][PHY_DW-1:0] regs;
    logic [NREG-1:0][PHY_DW-1:0] nxt;
    logic link_q;
    logic apply_pend;
    logic soft_rst;
    logic apply_link;

    assign soft_rst   = wr_en && (wr_idx == IDX_W'(RI_CTRL)) && wr_data[SOFT_RST_BIT];
    assign apply_link = soft_rst || apply_pend || (link_up != link_q);

    for (genvar g = 0; g < NREG; g++) begin : g_word
        localparam logic [PHY_DW-1:0] RST_V = phy_reset_value(g);
        localparam bit                RO    = is_read_only(g);
        logic [PHY_DW-1:0] stored;

        always_comb begin
            if (soft_rst)
                stored = RST_V;
            else if (wr_en && (wr_idx == IDX_W'(g)) && !RO)
                stored = wr_data;
            else
                stored = regs[g];
        end

        if (g == RI_STAT) begin : g_stat
            assign nxt[g] = !apply_link ? stored :
                            (link_up ? (stored | LINK_MASK) : (stored & ~LINK_MASK));
        end else if (g == RI_LPA) begin : g_lpa
            assign nxt[g] = !apply_link ? stored :
                            (link_up ? (stored | LPA_UP_SET) : (stored & LPA_DN_KEEP));
        end else begin : g_plain
            assign nxt[g] = stored;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= phy_reset_value(i);
            link_q     <= 1'b0;
            apply_pend <= 1'b1;
        end else begin
            regs       <= nxt;
            link_q     <= link_up;
            apply_pend <= 1'b0;
        end
    end

    assign rd_data = regs[rd_idx];

    assert_link_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up != link_q) |=> (regs[RI_STAT][2] == $past(link_up)));

    assert_soft_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (regs[RI_CTRL] == phy_reset_value(RI_CTRL)) && (regs[RI_ADV] == phy_reset_value(RI_ADV)));

    assert_id_ignores_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx == IDX_W'(RI_ID1)) && !soft_rst) |=> $stable(regs[RI_ID1]));
endmodule

// File: rtl/phy_mgmt_seq.sv
module phy_mgmt_seq
    import phy_mgmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_we,
    input  logic want_wr,
    input  logic want_rd,
    output logic do_write,
    output logic do_read
);
    seq_state_t state, state_nxt;
    logic rd_pend;

    always_comb begin
        state_nxt = state;
        unique case (state)
            SEQ_IDLE: begin
                if (cmd_we && want_wr)      state_nxt = SEQ_WRITE;
                else if (cmd_we && want_rd) state_nxt = SEQ_READ;
            end
            SEQ_WRITE: state_nxt = rd_pend ? SEQ_READ : SEQ_IDLE;
            SEQ_READ:  state_nxt = SEQ_IDLE;
            default:   state_nxt = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            rd_pend <= 1'b0;
        end else begin
            state <= state_nxt;
            if (state == SEQ_IDLE && cmd_we) rd_pend <= want_rd;
            else if (state != SEQ_IDLE)      rd_pend <= 1'b0;
        end
    end

    always_comb begin
        do_write = 1'b0;
        do_read  = 1'b0;
        unique case (state)
            SEQ_IDLE:  ;
            SEQ_WRITE: do_write = 1'b1;
            SEQ_READ:  do_read  = 1'b1;
            default:   ;
        endcase
    end

    assert_write_then_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_WRITE && rd_pend) |=> (state == SEQ_READ));

    assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_READ && cmd_we) |=> (state == SEQ_IDLE));
endmodule

// File: rtl/phy_mgmt_front.sv
module phy_mgmt_front
    import phy_mgmt_pkg::*;
#(
    parameter int PHY_ADDR = 1,
    parameter int HOST_AW  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr_en,
    input  logic               host_rd_en,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    input  logic               link_up
);
    logic [FLD_W-1:0]  fiad_q, rgad_q;
    logic [PHY_DW-1:0] txd_q, rxd_q;
    logic scan_q, lfail_q, link_prev_q;

    logic sel_cmd, sel_addr, sel_txd;
    logic phy_hit, idx_ok, direct_wr;
    logic do_write, do_read;
    logic rf_wr_en;
    logic [PHY_DW-1:0] rf_wr_data, rf_rd_data;
    logic unused_wdata;

    assign sel_cmd  = host_wr_en && (host_addr == HOST_AW'(HR_CMD));
    assign sel_addr = host_wr_en && (host_addr == HOST_AW'(HR_ADDR));
    assign sel_txd  = host_wr_en && (host_addr == HOST_AW'(HR_TXD));

    assign phy_hit   = (fiad_q == FLD_W'(PHY_ADDR));
    assign idx_ok    = (rgad_q < FLD_W'(NREG));
    assign direct_wr = sel_txd && phy_hit && idx_ok;

    assign rf_wr_en   = direct_wr || (do_write && phy_hit && idx_ok);
    assign rf_wr_data = direct_wr ? host_wdata[PHY_DW-1:0] : txd_q;

    assign unused_wdata = ^{host_wdata[31:PHY_DW]};

    phy_mgmt_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_we   (sel_cmd),
        .want_wr  (host_wdata[CMD_WR_BIT]),
        .want_rd  (host_wdata[CMD_RD_BIT]),
        .do_write (do_write),
        .do_read  (do_read)
    );

    phy_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .link_up (link_up),
        .wr_en   (rf_wr_en),
        .wr_idx  (rgad_q[IDX_W-1:0]),
        .wr_data (rf_wr_data),
        .rd_idx  (rgad_q[IDX_W-1:0]),
        .rd_data (rf_rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fiad_q      <= '0;
            rgad_q      <= '0;
            txd_q       <= '0;
            rxd_q       <= '0;
            scan_q      <= 1'b0;
            lfail_q     <= 1'b0;
            link_prev_q <= 1'b0;
        end else begin
            link_prev_q <= link_up;
            if (sel_addr) begin
                fiad_q <= host_wdata[FLD_W-1:0];
                rgad_q <= host_wdata[8 +: FLD_W];
            end
            if (sel_txd) txd_q <= host_wdata[PHY_DW-1:0];
            if (sel_cmd) scan_q <= host_wdata[CMD_SCAN_BIT];
            if (do_read) begin
                rxd_q   <= !phy_hit ? {PHY_DW{1'b1}} : (idx_ok ? rf_rd_data : '0);
                lfail_q <= !link_up;
            end else if (scan_q && (link_up != link_prev_q)) begin
                lfail_q <= !link_up;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (host_rd_en) begin
            case (host_addr)
                HOST_AW'(HR_CMD):  host_rdata <= {31'b0, scan_q};
                HOST_AW'(HR_ADDR): host_rdata <= {19'b0, rgad_q, 3'b0, fiad_q};
                HOST_AW'(HR_TXD):  host_rdata <= {16'b0, txd_q};
                HOST_AW'(HR_RXD):  host_rdata <= {16'b0, rxd_q};
                HOST_AW'(HR_STS):  host_rdata <= {31'b0, lfail_q};
                default:           host_rdata <= '0;
            endcase
        end
    end

    assert_absent_phy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (do_read && !phy_hit) |=> (rxd_q == 16'hFFFF));

    assert_high_index_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (do_read && phy_hit && !idx_ok) |=> (rxd_q == '0));

    assert_read_lfail_R9: assert property (@(posedge clk) disable iff (!rst_n)
        do_read |=> (lfail_q == !$past(link_up)));

    assert_scan_lfail_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_q && (link_up != link_prev_q)) |=> (lfail_q == !$past(link_up)));
endmodule

// File: tb/test_phy_mgmt_front.sv
`timescale 1ns/1ps
module test_phy_mgmt_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic        host_rd_en = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        link_up = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    logic [15:0] m [16];
    logic        mlink, mscan, mlf;
    logic [4:0]  mfiad, mrgad;
    logic [15:0] mtxd;

    phy_mgmt_front i_phy_mgmt_front (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .link_up(link_up)
    );

    always #4 clk = ~clk;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] rst_word(int i);
        case (i)
            0: return 16'h1000;
            1: return 16'h7848;
            2: return 16'h2000;
            3: return 16'h5C90;
            4: return 16'h01E1;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic m_apply_link();
        m[1] = mlink ? (m[1] | 16'h0004) : (m[1] & ~16'h0004);
        m[5] = mlink ? (m[5] | 16'h01E1) : (m[5] & 16'h01FF);
    endtask

    task automatic m_phy_write(logic [15:0] v);
        if (mfiad == 5'd1 && mrgad < 5'd16) begin
            if (mrgad == 5'd0 && v[15]) begin
                for (int i = 0; i < 16; i++) m[i] = rst_word(i);
                m_apply_link();
            end else if (!(mrgad == 5'd1 || mrgad == 5'd2 || mrgad == 5'd3)) begin
                m[mrgad[3:0]] = v;
            end
        end
    endtask

    function automatic logic [15:0] exp_rxd();
        if (mfiad != 5'd1) return 16'hFFFF;
        if (mrgad >= 5'd16) return 16'h0000;
        return m[mrgad[3:0]];
    endfunction

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(int idx, logic [31:0] d);
        host_wr_en = 1'b1; host_addr = 3'(idx); host_wdata = d;
        @(posedge clk); @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic host_read(int idx, output logic [31:0] d);
        host_rd_en = 1'b1; host_addr = 3'(idx);
        @(posedge clk); @(negedge clk);
        host_rd_en = 1'b0;
        d = host_rdata;
    endtask

    task automatic set_addr(logic [4:0] f, logic [4:0] r);
        host_write(1, {19'b0, r, 3'b0, f});
        mfiad = f; mrgad = r;
    endtask

    task automatic set_txd(logic [15:0] v);
        host_write(2, {16'hA5A5, v});
        mtxd = v;
        m_phy_write(v);
    endtask

    task automatic set_scan(logic s);
        host_write(0, {31'b0, s});
        mscan = s;
    endtask

    task automatic set_link(logic l);
        link_up = l;
        mlink = l;
        m_apply_link();
        if (mscan) mlf = !l;
        idle(1);
    endtask

    task automatic cmd_write();
        host_write(0, {29'b0, 1'b1, 1'b0, mscan});
        idle(2);
        m_phy_write(mtxd);
    endtask

    task automatic cmd_read(output logic [15:0] got);
        logic [31:0] d;
        host_write(0, {29'b0, 1'b0, 1'b1, mscan});
        idle(2);
        mlf = !mlink;
        host_read(3, d);
        got = d[15:0];
    endtask

    task automatic read_model(string tag);
        logic [15:0] got;
        logic [15:0] e;
        e = exp_rxd();
        cmd_read(got);
        check(tag, {16'b0, got}, {16'b0, e});
    endtask

    task automatic read_word(logic [4:0] r, logic [15:0] exp, string tag);
        logic [15:0] got;
        set_addr(5'd1, r);
        cmd_read(got);
        check(tag, {16'b0, got}, {16'b0, exp});
    endtask

    initial begin
        idle(200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [15:0] got;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) m[i] = rst_word(i);
        mlink = 1'b0; mscan = 1'b0; mlf = 1'b0; mfiad = '0; mrgad = '0; mtxd = '0;
        m_apply_link();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R1 / R13: host registers zero after reset, unmapped indices zero
        for (int i = 0; i < 8; i++) begin
            host_read(i, d);
            check(i < 5 ? "R1 host reg reset" : "R13 unmapped index", d, 32'h0);
        end
        // R13: rdata holds while rd_en is low
        idle(2);
        check("R13 rdata hold", host_rdata, 32'h0);

        // R1: PHY reset image with link down
        read_word(5'd0, 16'h1000, "R1 ctrl reset");
        read_word(5'd1, 16'h7848, "R1 status reset");
        read_word(5'd2, 16'h2000, "R1 id1 reset");
        read_word(5'd3, 16'h5C90, "R1 id2 reset");
        read_word(5'd4, 16'h01E1, "R1 adv reset");
        read_word(5'd5, 16'h0000, "R1 lpa reset");
        read_word(5'd9, 16'h0000, "R1 other reset");

        // R5: address field layout
        host_write(1, 32'hFFFF_FFFF);
        host_read(1, d);
        check("R5 addr readback mask", d, 32'h0000_1F1F);
        set_addr(5'h1A, 5'h13);
        host_read(1, d);
        check("R5 addr fields", d, 32'h0000_131A);

        // R2: link effects
        set_link(1'b1);
        read_word(5'd1, 16'h784C, "R2 status link up");
        read_word(5'd5, 16'h01E1, "R2 lpa link up");
        set_link(1'b0);
        read_word(5'd1, 16'h7848, "R2 status link down");
        read_word(5'd5, 16'h01E1, "R2 lpa and-mask keeps low bits");
        set_addr(5'd1, 5'd5);
        set_txd(16'hFFFF);
        set_link(1'b1);
        read_word(5'd5, 16'hFFFF, "R2 lpa or");
        set_link(1'b0);
        read_word(5'd5, 16'h01FF, "R2 lpa and 0x01FF");

        // R4: read-only words and plain stores
        set_addr(5'd1, 5'd2);
        set_txd(16'h1234);
        read_word(5'd2, 16'h2000, "R4 id1 ignores write");
        set_addr(5'd1, 5'd1);
        set_txd(16'h0000);
        read_word(5'd1, 16'h7848, "R4 status ignores write");
        set_addr(5'd1, 5'd4);
        set_txd(16'h0ABC);
        read_word(5'd4, 16'h0ABC, "R4 adv stores");
        set_addr(5'd1, 5'd0);
        set_txd(16'h0100);
        read_word(5'd0, 16'h0100, "R4 ctrl stores without bit 15");

        // R3: soft reset through a command write
        set_addr(5'd2, 5'd0);
        set_txd(16'h8000);
        set_addr(5'd1, 5'd0);
        cmd_write();
        read_word(5'd0, 16'h1000, "R3 soft reset ctrl");
        read_word(5'd4, 16'h01E1, "R3 soft reset adv");
        read_word(5'd5, 16'h0000, "R3 soft reset lpa with link down");

        // R7: absent PHY
        set_addr(5'd3, 5'd4);
        set_txd(16'h5555);
        cmd_write();
        cmd_read(got);
        check("R7 absent phy reads ones", {16'b0, got}, 32'h0000_FFFF);
        read_word(5'd4, 16'h01E1, "R7 absent phy write ignored");

        // R8: direct write through transmit data
        set_addr(5'd1, 5'd7);
        set_txd(16'hBEEF);
        host_read(2, d);
        check("R8 txd latch low half", d, 32'h0000_BEEF);
        read_word(5'd7, 16'hBEEF, "R8 direct phy write");

        // R6: write then read in one command
        set_addr(5'd2, 5'd8);
        set_txd(16'h0F0F);
        set_addr(5'd1, 5'd8);
        host_write(0, 32'h0000_0006);
        idle(2);
        m_phy_write(mtxd);
        host_read(3, d);
        check("R6 write then read", d, 32'h0000_0F0F);

        // R9: read copies inverted link
        set_link(1'b1);
        read_word(5'd0, 16'h1000, "R9 read with link up");
        host_read(4, d);
        check("R9 lfail after read link up", d, 32'h0);
        set_link(1'b0);
        host_read(4, d);
        check("R10 scan off keeps lfail", d, 32'h0);
        read_word(5'd0, 16'h1000, "R9 read with link down");
        host_read(4, d);
        check("R9 lfail after read link down", d, 32'h1);

        // R10: scanning
        set_scan(1'b1);
        host_read(0, d);
        check("R6 scan bit readback", d, 32'h1);
        set_link(1'b1);
        host_read(4, d);
        check("R10 scan link up", d, 32'h0);
        set_link(1'b0);
        host_read(4, d);
        check("R10 scan link down", d, 32'h1);
        set_scan(1'b0);

        // R11: high register address
        set_addr(5'd1, 5'd17);
        set_txd(16'h3333);
        cmd_write();
        cmd_read(got);
        check("R11 high index reads zero", {16'b0, got}, 32'h0);
        read_word(5'd1, 16'h7848, "R11 no alias onto word 1");

        // R12: command while busy is ignored
        set_addr(5'd2, 5'd4);
        set_txd(16'h7777);
        set_addr(5'd1, 5'd4);
        host_write(0, 32'h0000_0002);
        host_write(0, 32'h0000_0004);
        idle(3);
        host_read(3, d);
        check("R12 first read completes", d, 32'h0000_01E1);
        read_word(5'd4, 16'h01E1, "R12 busy write dropped");

        // Randomized mix checked against the model
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 6);
            case (op)
                0: set_addr(($urandom % 4 == 0) ? 5'($urandom) : 5'd1, 5'($urandom % 20));
                1: begin
                    logic [15:0] v;
                    v = 16'($urandom);
                    if ($urandom % 8 != 0) v[15] = 1'b0;
                    set_txd(v);
                end
                2: cmd_write();
                3: begin
                    read_model("R6 random read");
                    host_read(4, d);
                    check("R9 random lfail", d, {31'b0, mlf});
                end
                4: begin
                    set_link(!mlink);
                    host_read(4, d);
                    check("R10 random lfail", d, {31'b0, mlf});
                end
                default: set_scan(1'($urandom));
            endcase
        end
        for (int r = 0; r < 16; r++) read_word(5'(r), m[r], "R4 final sweep");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule